// File: doc/BRIEF.md
# AES3 Transmit Channel-Status Assembler

This block produces the three per-subframe control bits of an AES3-style transmitter: the channel-status bit C, the validity bit V and the user bit U. It runs on a master clock and watches an asynchronous input left/right clock. Every edge of that clock, rising or falling, opens a new subframe. For each subframe the block emits one strobe that carries the three bits and the subframe's position inside the 192-frame (384-subframe) channel-status block. A downstream framer and biphase encoder picks these up and puts them into the stream.

Channel status is chosen by a strap. In parallel-pin mode a full 192-bit channel-status block is built from four static pins: copy, original, pre-emphasis and audio. One bit is sent per frame, and both subframes of a frame carry the same bit. In serial mode the copy pin itself is the C bit, sampled once per subframe. A block-start pin is set as an output or an input by a direction strap. As an output it marks the first subframe of each block. As an input it forces block alignment once it has been held high long enough.

The output side is a valid-only stream with no ready. The subframe rate is set by the left/right clock, so the consumer cannot exert back-pressure. It must take each `sf_stb` pulse in the cycle it is asserted. Each half-period of the left/right clock must last at least two master-clock cycles.

Top module: `aes_cs_assembler`

## Requirements
- R1: While reset is held and right after it, `sf_stb`, `sf_pos`, `sf_c`, `sf_v`, `sf_u` and `blk_sync_o` are all 0.
- R2: Each edge of `lrck`, rising or falling, gives exactly one single-cycle `sf_stb` pulse. With that pulse, `sf_v` and `sf_u` carry the levels of `valid_flag_in` and `user_bit_in` sampled at that edge.
- R3: The first subframe after reset reports `sf_pos` 0. Each later subframe reports the previous position plus one, and position 383 is followed by 0.
- R4: With `blk_dir_out` high, `blk_sync_oe` is 1. `blk_sync_o` is high for the whole subframe whose position is 0 and low during every other subframe.
- R5: With `blk_dir_out` low, `blk_sync_oe` and `blk_sync_o` are 0. If `blk_sync_i` is held high for at least 3 master-clock cycles, the subframe in progress becomes position 0, so the next subframe reports position 1.
- R6: `blk_sync_i` has no effect on positions when it is high for fewer than 3 cycles, or at any time while `blk_dir_out` is high.
- R7: In parallel mode (`serial_cs` low), the subframe at position p carries channel-status bit p/2 (integer division). The two subframes of a frame always carry the same C value.
- R8: Parallel mode, emphasis: with `preemph_n` low, bits 2, 3 and 4 are 1, 1 and 0 (50/15 µs). With `preemph_n` high, all three are 0.
- R9: Parallel mode, copy control: with {`copy_or_c`,`orig_flag`} equal to 00, bits 0, 6 and 15 are all 0. With 01, only bit 15 is 1. With 10, only bit 6 is 1. With 11, only bit 0 is 1. Bit 0 is the professional flag, bit 6 the copy bit and bit 15 the generation (L) bit.
- R10: Parallel mode: bit 1 equals `audio_flag` (1 means non-audio). Every bit not named in R8 to R10 is 0.
- R11: In serial mode (`serial_cs` high), `sf_c` equals the level of `copy_or_c` sampled at the subframe's `lrck` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrck | input | 1 | Input left/right clock; each edge opens a subframe |
| serial_cs | input | 1 | Mode strap: 0 parallel-pin channel status, 1 serial C bit |
| blk_dir_out | input | 1 | Block-start direction strap: 1 output, 0 input |
| blk_sync_i | input | 1 | Block-start input (used when the strap is 0) |
| blk_sync_o | output | 1 | Block-start output level |
| blk_sync_oe | output | 1 | Drive enable for the block-start pad |
| copy_or_c | input | 1 | Copy pin (parallel) or direct C bit (serial) |
| orig_flag | input | 1 | Original pin (parallel mode) |
| preemph_n | input | 1 | Pre-emphasis pin, low selects 50/15 µs |
| audio_flag | input | 1 | Audio/non-audio pin (parallel mode) |
| valid_flag_in | input | 1 | Validity bit source |
| user_bit_in | input | 1 | User bit source |
| sf_stb | output | 1 | One-cycle strobe per subframe |
| sf_pos | output | 9 | Subframe position in block, 0..383 |
| sf_c | output | 1 | Channel-status bit for the subframe |
| sf_v | output | 1 | Validity bit for the subframe |
| sf_u | output | 1 | User bit for the subframe |

## Verification
Some properties are checked by assertions on every cycle. The position counter stays below 384 and wraps to 0. A qualified block-start pulse lasts one cycle and needs the input high for consecutive cycles. A forced start zeroes the position. Strobes never come back-to-back. The two subframes of a parallel-mode frame carry equal C bits. The block-start output rises only with position 0 and never when the pad is not driven. The bench scenarios are needed for the rest. They show the actual channel-status bit layout for each pin combination, and that V, U and serial C follow the pins one subframe at a time. They also show that a short or wrong-direction start pulse leaves the count alone, and that a forced start puts the next subframe at position 1.

// File: rtl/aes_cs_pkg.sv
package aes_cs_pkg;

  // Channel-status bit positions used by the parallel-pin expansion
  localparam int unsigned CSB_PRO   = 0;
  localparam int unsigned CSB_NAUD  = 1;
  localparam int unsigned CSB_EMP0  = 2;
  localparam int unsigned CSB_EMP1  = 3;
  localparam int unsigned CSB_EMP2  = 4;
  localparam int unsigned CSB_COPY  = 6;
  localparam int unsigned CSB_GEN   = 15;

  // Static pin bundle latched per frame in parallel mode
  typedef struct packed {
    logic cp;
    logic og;
    logic pe_n;
    logic au;
  } cs_pins_t;

  // Expand static pins into channel-status bit number b
  function automatic logic cs_bit(input int unsigned b, input cs_pins_t p);
    logic r;
    r = 1'b0;
    case (b)
      CSB_PRO:  r = p.cp & p.og;
      CSB_NAUD: r = p.au;
      CSB_EMP0: r = ~p.pe_n;
      CSB_EMP1: r = ~p.pe_n;
      CSB_EMP2: r = 1'b0;
      CSB_COPY: r = p.cp & ~p.og;
      CSB_GEN:  r = ~p.cp & p.og;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/acs_sync.sv
module acs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_i;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/acs_start_qual.sv
module acs_start_qual #(
  parameter int QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic in_i,
  output logic force_o
);
  localparam int CW = $clog2(QUAL + 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (!en_i || !in_i) run_cnt <= '0;
    else if (run_cnt != CW'(QUAL)) run_cnt <= run_cnt + CW'(1);
  end

  assign force_o = en_i & in_i & (run_cnt == CW'(QUAL - 1));

  AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |=> !force_o); // R5
  AST_FORCE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    force_o |-> in_i && $past(in_i) && $past(en_i)); // R6
endmodule

// File: rtl/acs_position.sv
module acs_position #(
  parameter int FRAMES = 192,
  localparam int SF    = 2 * FRAMES,
  localparam int IW    = $clog2(SF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          force_i,
  output logic [IW-1:0] cur_o,
  output logic [IW-1:0] nxt_o
);
  localparam logic [IW-1:0] LAST = IW'(SF - 1);

  logic [IW-1:0] cur_idx;

  // Position the subframe opening this cycle will take
  always_comb begin
    if (force_i) nxt_o = '0;
    else if (cur_idx == LAST) nxt_o = '0;
    else nxt_o = cur_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_idx <= LAST;
    else if (adv_i) cur_idx <= nxt_o;
    else if (force_i) cur_idx <= '0;
  end

  assign cur_o = cur_idx;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cur_idx <= LAST); // R3
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !force_i && cur_idx == LAST |=> cur_idx == '0); // R3
  AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    force_i && !adv_i |=> cur_idx == '0); // R5
endmodule

// File: rtl/aes_cs_assembler.sv
module aes_cs_assembler
  import aes_cs_pkg::*;
#(
  parameter int FRAMES      = 192,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3,
  localparam int IW         = $clog2(2 * FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrck,
  input  logic          serial_cs,
  input  logic          blk_dir_out,
  input  logic          blk_sync_i,
  output logic          blk_sync_o,
  output logic          blk_sync_oe,
  input  logic          copy_or_c,
  input  logic          orig_flag,
  input  logic          preemph_n,
  input  logic          audio_flag,
  input  logic          valid_flag_in,
  input  logic          user_bit_in,
  output logic          sf_stb,
  output logic [IW-1:0] sf_pos,
  output logic          sf_c,
  output logic          sf_v,
  output logic          sf_u
);
  localparam int NPIN = 10;
  localparam int P_LR = 0, P_CP = 1, P_V = 2, P_U = 3, P_BS = 4;
  localparam int P_OG = 5, P_PE = 6, P_AU = 7, P_SER = 8, P_DIR = 9;

  logic [NPIN-1:0] raw, s;
  logic            lr_prev, lr_edge, force_start;
  logic [IW-1:0]   cur_idx, nxt_idx;
  cs_pins_t        live_pins, frame_pins, use_pins;
  logic            par_c, c_next;
  logic            sf_ser, prev_c, prev_ser;
  logic [IW-1:0]   prev_pos;

  assign raw = {blk_dir_out, serial_cs, audio_flag, preemph_n, orig_flag,
                blk_sync_i, user_bit_in, valid_flag_in, copy_or_c, lrck};

  acs_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_prev <= 1'b0;
    else lr_prev <= s[P_LR];
  end
  assign lr_edge = s[P_LR] ^ lr_prev;

  acs_start_qual #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .en_i(~s[P_DIR]), .in_i(s[P_BS]),
    .force_o(force_start)
  );

  acs_position #(.FRAMES(FRAMES)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv_i(lr_edge), .force_i(force_start),
    .cur_o(cur_idx), .nxt_o(nxt_idx)
  );

  // Parallel-pin expansion: pins latched on the first subframe of a frame
  assign live_pins = '{cp: s[P_CP], og: s[P_OG], pe_n: s[P_PE], au: s[P_AU]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_pins <= '0;
    else if (lr_edge && !nxt_idx[0]) frame_pins <= live_pins;
  end

  assign use_pins = nxt_idx[0] ? frame_pins : live_pins;
  assign par_c    = cs_bit(int'(nxt_idx >> 1), use_pins);
  assign c_next   = s[P_SER] ? s[P_CP] : par_c;

  // Subframe output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_stb <= 1'b0;
      sf_pos <= '0;
      sf_c   <= 1'b0;
      sf_v   <= 1'b0;
      sf_u   <= 1'b0;
      sf_ser <= 1'b0;
    end else begin
      sf_stb <= lr_edge;
      if (lr_edge) begin
        sf_pos <= nxt_idx;
        sf_c   <= c_next;
        sf_v   <= s[P_V];
        sf_u   <= s[P_U];
        sf_ser <= s[P_SER];
      end
    end
  end

  assign blk_sync_oe = s[P_DIR];
  assign blk_sync_o  = s[P_DIR] & (cur_idx == '0);

  // History of the last emitted subframe, for the pairing check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c   <= 1'b0;
      prev_ser <= 1'b1;
      prev_pos <= '0;
    end else if (sf_stb) begin
      prev_c   <= sf_c;
      prev_ser <= sf_ser;
      prev_pos <= sf_pos;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |=> !sf_stb); // R2
  AST_FRAME_PAIR_C: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb && !sf_ser && !prev_ser && sf_pos[0] && (sf_pos == prev_pos + IW'(1))
      |-> sf_c == prev_c); // R7
  AST_BLK_OUT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_sync_o) && !$past(force_start) |-> sf_pos == '0); // R4
  AST_BLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_sync_oe |-> !blk_sync_o); // R5
endmodule

// File: tb/aes_cs_assembler_test.sv
module aes_cs_assembler_test;
  localparam int SF = 384;

  logic clk = 1'b0, rst_n = 1'b0, lrck = 1'b0;
  logic serial_cs = 1'b0, blk_dir_out = 1'b1, blk_sync_i = 1'b0;
  logic copy_or_c = 1'b0, orig_flag = 1'b0, preemph_n = 1'b1, audio_flag = 1'b0;
  logic valid_flag_in = 1'b0, user_bit_in = 1'b0;
  logic blk_sync_o, blk_sync_oe, sf_stb, sf_c, sf_v, sf_u;
  logic [8:0] sf_pos;

  int n_run = 0, n_fail = 0;
  bit lr_run = 1'b0;

  aes_cs_assembler uut (
    .clk(clk), .rst_n(rst_n), .lrck(lrck), .serial_cs(serial_cs),
    .blk_dir_out(blk_dir_out), .blk_sync_i(blk_sync_i),
    .blk_sync_o(blk_sync_o), .blk_sync_oe(blk_sync_oe),
    .copy_or_c(copy_or_c), .orig_flag(orig_flag), .preemph_n(preemph_n),
    .audio_flag(audio_flag), .valid_flag_in(valid_flag_in),
    .user_bit_in(user_bit_in), .sf_stb(sf_stb), .sf_pos(sf_pos),
    .sf_c(sf_c), .sf_v(sf_v), .sf_u(sf_u)
  );

  always #2.5 clk = ~clk;

  // Left/right clock: one edge every 16 master-clock cycles
  initial begin
    forever begin
      repeat (16) @(negedge clk);
      if (lr_run) lrck = ~lrck;
    end
  end

  initial begin
    #(190000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // Parallel-pin vectors {copy, orig, preemph_n, audio}
  localparam logic [3:0] VEC [5] = '{4'b0010, 4'b0101, 4'b1010, 4'b1100, 4'b0011};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb();
    int guard = 0;
    @(negedge clk);
    while (!sf_stb && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Expected channel-status bit from R8, R9 and R10
  function automatic logic exp_cs(input int b, input logic [3:0] v);
    logic cp, og, pe_n, au;
    {cp, og, pe_n, au} = v;
    case (b)
      0: return cp & og;
      1: return au;
      2: return ~pe_n;
      3: return ~pe_n;
      6: return cp & ~og;
      15: return ~cp & og;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    int p;
    // R1 reset state
    repeat (4) @(negedge clk);
    check(!sf_stb && sf_pos == 0 && !sf_c && !sf_v && !sf_u && !blk_sync_o,
          "R1 reset", {sf_stb, sf_c, sf_v, sf_u, blk_sync_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!sf_stb && !blk_sync_o, "R1 after reset", {sf_stb, blk_sync_o}, 0);
    lr_run = 1'b1;

    // R3/R4 first subframe at position 0, block-start output high across it
    wait_stb();
    check(sf_pos == 0, "R3 first position", sf_pos, 0);
    check(blk_sync_oe && blk_sync_o, "R4 start high", blk_sync_o, 1);
    repeat (8) @(negedge clk);
    check(blk_sync_o, "R4 start held", blk_sync_o, 1);
    wait_stb();
    check(sf_pos == 1 && !blk_sync_o, "R4 start low after", blk_sync_o, 0);

    // R7-R10 parallel vectors, one full block each; R3 sequence and wrap
    for (int k = 0; k < 5; k++) begin
      int errs = 0, first_b = -1;
      {copy_or_c, orig_flag, preemph_n, audio_flag} = VEC[k];
      do wait_stb(); while (sf_pos != 0);
      for (int i = 0; i < SF; i++) begin
        if (i > 0) wait_stb();
        if (sf_pos != i || sf_c != exp_cs(i / 2, VEC[k])) begin
          errs++;
          if (first_b < 0) first_b = i;
        end
      end
      check(errs == 0, $sformatf("R7 R8 R9 R10 vector %0d first bad subframe", k), first_b, -1);
      wait_stb();
      check(sf_pos == 0, "R3 wrap", sf_pos, 0);
    end

    // R2/R11 serial mode: V, U and C follow the pins per subframe
    serial_cs = 1'b1;
    wait_stb();
    for (int i = 0; i < 12; i++) begin
      logic [2:0] pat;
      pat = 3'(i * 5 + 3);
      {copy_or_c, valid_flag_in, user_bit_in} = pat;
      wait_stb();
      check(sf_c == pat[2], "R11 serial C", sf_c, pat[2]);
      check({sf_v, sf_u} == pat[1:0], "R2 V and U", {sf_v, sf_u}, pat[1:0]);
    end
    serial_cs = 1'b0;

    // R5 input mode: 3-cycle high forces start
    blk_dir_out = 1'b0;
    wait_stb();
    wait_stb();
    check(!blk_sync_oe && !blk_sync_o, "R5 pad released", blk_sync_oe, 0);
    blk_sync_i = 1'b1;
    repeat (3) @(negedge clk);
    blk_sync_i = 1'b0;
    wait_stb();
    check(sf_pos == 1, "R5 forced start", sf_pos, 1);

    // R6 two-cycle pulse is ignored
    blk_sync_i = 1'b1;
    repeat (2) @(negedge clk);
    blk_sync_i = 1'b0;
    wait_stb();
    check(sf_pos == 2, "R6 short pulse ignored", sf_pos, 2);

    // R6 output mode ignores a long pulse
    blk_dir_out = 1'b1;
    wait_stb();
    p = sf_pos;
    blk_sync_i = 1'b1;
    repeat (5) @(negedge clk);
    blk_sync_i = 1'b0;
    wait_stb();
    check(sf_pos == p + 1, "R6 output mode ignores input", sf_pos, p + 1);
    check(blk_sync_oe && !blk_sync_o, "R4 low off start", blk_sync_o, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule